// File: doc/BRIEF.md
# Audio Master Clock Divider

This block runs on a fast audio source clock and derives from it three kinds of timing for an audio serial port: a master clock level of roughly even duty, a single-cycle frame strobe, and a bit-clock enable strobe. Every output is a level or an enable computed by counters in the source clock domain. No new clock domain is created. Two 6-bit fields set the ratios. The master clock period is `div_sel + 1` source cycles. The frame period is `32 * (fs_ratio + 1)` source cycles. The master-clock-per-frame ratio is therefore `32 * (fs_ratio + 1) / (div_sel + 1)`.

Generation runs only when the port is in master mode. A one-cycle start command begins it and a one-cycle stop command ends it. A stop never truncates a master clock period: the period in progress completes, and then the output is held low. A select input chooses the pin arrangement. With the select high, the generated master clock appears on the master clock pin. With the select low, nothing is generated onto that pin and an externally selected clock passes straight to the bit-clock pin. A new divider setting is adopted only at the terminal count of its own divider, so a period is never cut short.

Top module: `amclk_gen`

## Requirements
- R1: After reset, `gen_active`, `mck_pin`, `mck_ce`, `frame_stb` and `bit_ce` are all 0. With `mck_drive` = 0, `bck_pin` equals `sel_clk_in`.
- R2: A `clk_on` pulse with `master_mode` = 1 and `clk_off` = 0, sampled at a rising edge, sets `gen_active` from that edge on. The period counters start at zero. A `clk_on` pulse while `master_mode` = 0 has no effect.
- R3: While active, the master clock period is D = `div_sel`+1 source cycles. The level is 1 for the first ceil(D/2) cycles of each period and 0 for the rest, so D = 1 gives a constant 1. `mck_ce` is 1 in the last cycle of each period.
- R4: `frame_stb` is 1 for exactly one cycle, the last of every F = 32·(`fs_ratio`+1) active cycles. The first frame begins at the start edge.
- R5: In cycle k (0 ≤ k < F) of a frame, `bit_ce` is 1 exactly when floor((k+1)·64/F) > floor(k·64/F). This gives 64 enables per frame for `fs_ratio` ≥ 1 and an enable in every cycle for `fs_ratio` = 0.
- R6: The value of `div_sel` is captured at the start and at each master clock terminal count. The value of `fs_ratio` is captured at the start and at each frame terminal count. Changes between those points have no effect.
- R7: A `clk_off` pulse while active stops generation at the first master clock terminal count in or after that cycle. All outputs are then low. If `clk_on` and `clk_off` arrive together, `clk_off` wins. A `clk_on` after a pending `clk_off`, and before the stop, cancels the stop.
- R8: `master_mode` = 0 clears `gen_active` at the next edge, whatever point the period has reached.
- R9: With `mck_drive` = 1, `mck_pin` carries the generated level and `bck_pin` is 0. With `mck_drive` = 0, `mck_pin` is 0 and `bck_pin` equals `sel_clk_in`.
- R10: `div_sel`=7 with `fs_ratio`=63 yields 256 `mck_ce` pulses per frame. `div_sel`=0 with `fs_ratio`=47 yields 1536.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Audio source clock |
| rst_n | input | 1 | Active-low synchronous reset |
| master_mode | input | 1 | 1 = port is timing master, generation allowed |
| mck_drive | input | 1 | Pin select: 1 = generated master clock on `mck_pin` |
| div_sel | input | 6 | Master clock divisor minus one |
| fs_ratio | input | 6 | Frame length in units of 32 source cycles, minus one |
| clk_on | input | 1 | Start command pulse |
| clk_off | input | 1 | Stop command pulse |
| sel_clk_in | input | 1 | Externally selected clock, passed through when not generating |
| mck_pin | output | 1 | Master clock pin level |
| bck_pin | output | 1 | Bit-clock pin level |
| mck_ce | output | 1 | Strobe in the last cycle of each master clock period |
| frame_stb | output | 1 | Strobe in the last cycle of each frame |
| bit_ce | output | 1 | Bit-clock enable, 64 per frame |
| gen_active | output | 1 | Generation running |

## Verification
The bench targets odd divisors, where a wrong rounding of the high phase would shift the falling edge by one cycle. It also covers a divisor of one, where the level must stay high rather than toggle. Frame lengths that are not multiples of 64 cycles are exercised, since an integer-only bit enable period would drift and miss the 64th pulse in the final cycle. Divider fields are changed in mid-period, which catches a design that loads them immediately and produces one short period. Stop commands are placed in the middle of a period, at its terminal cycle, together with a start, and followed by a cancelling start; a naive stop would clip the master clock or ignore the cancel.

// File: rtl/amclk_pkg.sv
package amclk_pkg;

   // log2 of the master-clock-to-frame multiplier (32)
   localparam int unsigned SLOT_SHIFT_DFLT = 5;
   // bit clock enables per frame
   localparam int unsigned BCE_PER_FRAME_DFLT = 64;

   typedef enum logic {
      PIN_PASS = 1'b0,
      PIN_GEN  = 1'b1
   } pin_mode_e;

endpackage

// File: rtl/amclk_run_ctrl.sv
module amclk_run_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic master_mode,
   input  logic clk_on,
   input  logic clk_off,
   input  logic mck_term,
   output logic run_o
);

   logic run_q;
   logic pend_q;
   logic stop_now;

   // a stop request (new or pending, unless cancelled) completes at a terminal count
   assign stop_now = run_q && mck_term && (clk_off || (pend_q && !clk_on));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         pend_q <= 1'b0;
      end else if (!master_mode) begin
         run_q  <= 1'b0;
         pend_q <= 1'b0;
      end else if (!run_q) begin
         pend_q <= 1'b0;
         if (clk_on && !clk_off) begin
            run_q <= 1'b1;
         end
      end else if (stop_now) begin
         run_q  <= 1'b0;
         pend_q <= 1'b0;
      end else if (clk_off) begin
         pend_q <= 1'b1;
      end else if (clk_on) begin
         pend_q <= 1'b0;
      end
   end

   assign run_o = run_q;

   // R2
   start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run_q) |-> ($past(clk_on) && !$past(clk_off) && $past(master_mode)));

   // R7
   stop_at_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(run_q) && $past(master_mode)) |-> $past(mck_term));

   // R8
   mode_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !master_mode |=> !run_q);

endmodule

// File: rtl/amclk_mck_div.sv
module amclk_mck_div #(
   parameter int unsigned DIV_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div_field,
   output logic             mck_lvl,
   output logic             mck_term
);

   localparam int unsigned HW = DIV_W + 1;

   initial begin
      div_w_chk: assert (DIV_W >= 1 && DIV_W <= 16);
   end

   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] lat_q;
   logic [HW-1:0]    high_len;

   // ceil((lat+1)/2): odd divisors keep the extra cycle in the high phase
   assign high_len = ({1'b0, lat_q} + HW'(2)) >> 1;
   assign mck_term = run && (cnt_q == lat_q);
   assign mck_lvl  = run && ({1'b0, cnt_q} < high_len);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         lat_q <= '0;
      end else if (!run || mck_term) begin
         cnt_q <= '0;
         lat_q <= div_field;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R6
   div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !mck_term) |=> $stable(lat_q));

   // R3
   term_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mck_term |=> (cnt_q == '0));

endmodule

// File: rtl/amclk_frame_div.sv
module amclk_frame_div #(
   parameter int unsigned FS_W       = 6,
   parameter int unsigned SLOT_SHIFT = amclk_pkg::SLOT_SHIFT_DFLT,
   parameter int unsigned BCE        = amclk_pkg::BCE_PER_FRAME_DFLT
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic [FS_W-1:0] fs_field,
   output logic            frame_stb,
   output logic            bit_ce
);

   localparam int unsigned FW = FS_W + SLOT_SHIFT;
   localparam int unsigned AW = FW + 2;
   localparam int unsigned BW = $clog2(BCE + 1) + 1;

   initial begin
      bce_range_chk: assert (BCE >= 1 && BCE < (2 ** FW));
   end

   logic [FW-1:0]   cnt_q;
   logic [FS_W-1:0] lat_q;
   logic [AW-1:0]   acc_q;
   logic [AW-1:0]   frame_len;
   logic [AW-1:0]   sum;
   logic [AW-1:0]   wrapped;
   logic [AW-1:0]   acc_nxt;

   assign frame_len = (AW'(lat_q) + AW'(1)) << SLOT_SHIFT;
   assign frame_stb = run && (AW'(cnt_q) == frame_len - AW'(1));

   // fractional phase accumulator: an enable each time k*BCE crosses a multiple of F
   assign sum     = acc_q + AW'(BCE);
   assign bit_ce  = run && (sum >= frame_len);
   assign wrapped = sum - frame_len;
   assign acc_nxt = !bit_ce ? sum : ((wrapped >= frame_len) ? '0 : wrapped);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         acc_q <= '0;
         lat_q <= '0;
      end else if (!run || frame_stb) begin
         cnt_q <= '0;
         acc_q <= '0;
         lat_q <= fs_field;
      end else begin
         cnt_q <= cnt_q + 1'b1;
         acc_q <= acc_nxt;
      end
   end

   // enable tally used by the per-frame check below
   logic [BW-1:0] bce_tally;
   always_ff @(posedge clk) begin
      if (!rst_n || !run || frame_stb) begin
         bce_tally <= '0;
      end else if (bit_ce) begin
         bce_tally <= bce_tally + 1'b1;
      end
   end

   // R5
   bce_per_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_stb && lat_q != '0) |-> (bit_ce && bce_tally == BW'(BCE - 1)));

   // R4
   frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_stb |=> (cnt_q == '0));

   // R6
   fs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !frame_stb) |=> $stable(lat_q));

endmodule

// File: rtl/amclk_gen.sv
module amclk_gen #(
   parameter int unsigned DIV_W      = 6,
   parameter int unsigned FS_W       = 6,
   parameter int unsigned SLOT_SHIFT = amclk_pkg::SLOT_SHIFT_DFLT,
   parameter int unsigned BCE        = amclk_pkg::BCE_PER_FRAME_DFLT,
   parameter bit          PASS_THRU  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             master_mode,
   input  logic             mck_drive,
   input  logic [DIV_W-1:0] div_sel,
   input  logic [FS_W-1:0]  fs_ratio,
   input  logic             clk_on,
   input  logic             clk_off,
   input  logic             sel_clk_in,
   output logic             mck_pin,
   output logic             bck_pin,
   output logic             mck_ce,
   output logic             frame_stb,
   output logic             bit_ce,
   output logic             gen_active
);

   import amclk_pkg::*;

   logic run;
   logic mck_lvl;
   logic mck_term;
   pin_mode_e pin_mode;

   assign pin_mode = pin_mode_e'(mck_drive);

   amclk_run_ctrl u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .master_mode (master_mode),
      .clk_on      (clk_on),
      .clk_off     (clk_off),
      .mck_term    (mck_term),
      .run_o       (run)
   );

   amclk_mck_div #(.DIV_W(DIV_W)) u_mck (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .div_field (div_sel),
      .mck_lvl   (mck_lvl),
      .mck_term  (mck_term)
   );

   amclk_frame_div #(
      .FS_W       (FS_W),
      .SLOT_SHIFT (SLOT_SHIFT),
      .BCE        (BCE)
   ) u_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .fs_field  (fs_ratio),
      .frame_stb (frame_stb),
      .bit_ce    (bit_ce)
   );

   assign mck_ce     = mck_term;
   assign gen_active = run;
   assign mck_pin    = (pin_mode == PIN_GEN) ? mck_lvl : 1'b0;

   generate
      if (PASS_THRU) begin : g_pass
         assign bck_pin = (pin_mode == PIN_PASS) ? sel_clk_in : 1'b0;
      end else begin : g_nopass
         assign bck_pin = 1'b0;
      end
   endgenerate

   // R9
   pin_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mck_drive |-> !mck_pin);

   // R7
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !gen_active |-> !(mck_pin || mck_ce || frame_stb || bit_ce));

endmodule

// File: tb/tb_amclk_gen.sv
module tb_amclk_gen;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic master_mode = 1'b0;
   logic mck_drive = 1'b0;
   logic [5:0] div_sel = '0;
   logic [5:0] fs_ratio = '0;
   logic clk_on = 1'b0;
   logic clk_off = 1'b0;
   logic sel_clk_in = 1'b0;
   logic mck_pin, bck_pin, mck_ce, frame_stb, bit_ce, gen_active;

   always #10 clk = ~clk;

   amclk_gen dut (
      .clk(clk), .rst_n(rst_n), .master_mode(master_mode), .mck_drive(mck_drive),
      .div_sel(div_sel), .fs_ratio(fs_ratio), .clk_on(clk_on), .clk_off(clk_off),
      .sel_clk_in(sel_clk_in), .mck_pin(mck_pin), .bck_pin(bck_pin), .mck_ce(mck_ce),
      .frame_stb(frame_stb), .bit_ce(bit_ce), .gen_active(gen_active)
   );

   int total = 0;
   int bad = 0;
   bit done = 0;
   bit cmp_on = 0;
   string phase = "R1";

   task automatic chk(input string tag, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s (%s) %s: actual=%0d expected=%0d at %0t", tag, phase, what, act, exp, $time);
      end
   endtask

   // behavioural reference state
   int m_run = 0, m_pend = 0, m_mc = 0, m_fc = 0, m_dl = 0, m_fl = 0;

   always @(posedge clk) begin
      int flen, mterm, fterm, stop;
      if (!rst_n) begin
         m_run = 0; m_pend = 0; m_mc = 0; m_fc = 0; m_dl = 0; m_fl = 0;
      end else if (!master_mode) begin
         m_run = 0; m_pend = 0; m_mc = 0; m_fc = 0; m_dl = div_sel; m_fl = fs_ratio;
      end else if (m_run == 0) begin
         m_mc = 0; m_fc = 0; m_dl = div_sel; m_fl = fs_ratio; m_pend = 0;
         if (clk_on && !clk_off) m_run = 1;
      end else begin
         flen  = 32 * (m_fl + 1);
         mterm = (m_mc == m_dl);
         fterm = (m_fc == flen - 1);
         stop  = mterm && (clk_off || (m_pend && !clk_on));
         if (stop) begin
            m_run = 0; m_pend = 0; m_mc = 0; m_fc = 0; m_dl = div_sel; m_fl = fs_ratio;
         end else begin
            if (clk_off) m_pend = 1; else if (clk_on) m_pend = 0;
            if (mterm) begin m_mc = 0; m_dl = div_sel; end else m_mc = m_mc + 1;
            if (fterm) begin m_fc = 0; m_fl = fs_ratio; end else m_fc = m_fc + 1;
         end
      end
   end

   // R10 monitor
   int r10_exp = 0;
   int ce_cnt = 0;

   always @(negedge clk) begin
      int flen, e_lvl, e_ce, e_fr, e_bc;
      if (cmp_on) begin
         flen  = 32 * (m_fl + 1);
         e_lvl = m_run && (m_mc < (m_dl + 2) / 2);
         e_ce  = m_run && (m_mc == m_dl);
         e_fr  = m_run && (m_fc == flen - 1);
         e_bc  = m_run && (((m_fc + 1) * 64) / flen > (m_fc * 64) / flen);
         chk("R3", "mck_pin", int'(mck_pin), mck_drive ? e_lvl : 0);
         chk("R3", "mck_ce", int'(mck_ce), e_ce);
         chk("R4", "frame_stb", int'(frame_stb), e_fr);
         chk("R5", "bit_ce", int'(bit_ce), e_bc);
         chk("R7", "gen_active", int'(gen_active), m_run);
         chk("R9", "bck_pin", int'(bck_pin), mck_drive ? 0 : int'(sel_clk_in));
         if (mck_ce) ce_cnt++;
         if (frame_stb) begin
            if (r10_exp > 0) chk("R10", "mck periods per frame", ce_cnt, r10_exp);
            ce_cnt = 0;
         end
      end
   end

   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #2;
         sel_clk_in = ~sel_clk_in;
      end
   endtask

   task automatic pulse(input bit on, input bit off);
      @(posedge clk); #2;
      clk_on = on; clk_off = off;
      @(posedge clk); #2;
      clk_on = 0; clk_off = 0;
   endtask

   task automatic halt();
      @(posedge clk); #2;
      master_mode = 0;
      step(2);
      master_mode = 1;
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      step(3);
      @(posedge clk); #2; rst_n = 1;
      cmp_on = 1;
      @(negedge clk);
      // R1 reset state
      phase = "R1";
      chk("R1", "gen_active after reset", int'(gen_active), 0);
      chk("R1", "bck follows sel", int'(bck_pin), int'(sel_clk_in));
      chk("R1", "strobes idle", int'(mck_ce | frame_stb | bit_ce | mck_pin), 0);

      // R2 start ignored in slave mode
      phase = "R2";
      div_sel = 2; fs_ratio = 1;
      pulse(1, 0);
      step(3);
      @(negedge clk);
      chk("R2", "start ignored when slave", int'(gen_active), 0);

      // R3 R4 R5 odd divisor, 64-cycle frame, generated pins
      phase = "R3";
      master_mode = 1; mck_drive = 1;
      pulse(1, 0);
      @(negedge clk);
      chk("R2", "active after start", int'(gen_active), 1);
      step(200);

      // R6 change fields mid-period
      phase = "R6";
      div_sel = 4; fs_ratio = 2;
      step(1);
      @(negedge clk);
      chk("R6", "active after field change", int'(gen_active), 1);
      step(300);
      div_sel = 0; step(40);
      div_sel = 3; fs_ratio = 4; step(500);

      // R5 shortest frame
      phase = "R5";
      div_sel = 5; fs_ratio = 0;
      step(150);
      fs_ratio = 6; step(700);

      // R7 stop mid-period
      phase = "R7";
      div_sel = 5;
      step(20);
      pulse(0, 1);
      step(10);
      @(negedge clk);
      chk("R7", "stopped after period end", int'(gen_active), 0);
      chk("R7", "mck low when stopped", int'(mck_pin), 0);
      // both commands together: stop wins
      pulse(1, 0);
      step(9);
      pulse(1, 1);
      step(10);
      @(negedge clk);
      chk("R7", "stop wins over start", int'(gen_active), 0);
      // cancel pending stop
      pulse(1, 0);
      step(3);
      pulse(0, 1);
      pulse(1, 0);
      step(20);
      @(negedge clk);
      chk("R7", "start cancels pending stop", int'(gen_active), 1);

      // R8 mode drop stops at once
      phase = "R8";
      step(2);
      @(posedge clk); #2;
      master_mode = 0;
      @(negedge clk);
      @(negedge clk);
      chk("R8", "slave mode stops", int'(gen_active), 0);
      master_mode = 1;

      // R9 pass-through pin arrangement
      phase = "R9";
      mck_drive = 0;
      div_sel = 1; fs_ratio = 3;
      pulse(1, 0);
      step(300);
      @(negedge clk);
      chk("R9", "mck pin held low", int'(mck_pin), 0);
      chk("R9", "bck pin passes sel", int'(bck_pin), int'(sel_clk_in));
      halt();

      // R10 example ratios
      phase = "R10";
      mck_drive = 1;
      div_sel = 7; fs_ratio = 63;
      ce_cnt = 0; r10_exp = 256;
      pulse(1, 0);
      step(2048 * 3 + 10);
      r10_exp = 0;
      halt();
      div_sel = 0; fs_ratio = 47;
      ce_cnt = 0; r10_exp = 1536;
      pulse(1, 0);
      step(1536 * 3 + 10);
      r10_exp = 0;
      halt();

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule